// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Corrector

This block repairs a sector of stored data once a Reed-Solomon decoder has worked out where its errors are. The sector sits in a dual-port byte RAM outside the block. It is read as a stream of 9-bit symbols packed back to back across byte boundaries. On a `start` pulse the block captures three inputs: a decode status word, a small set of error words (each a 1-based symbol index and a 9-bit flip mask) and the 9 parity bytes that were read with the sector. It then applies each valid correction with a read-modify-write of the byte pair that holds the symbol.

A freshly erased sector reads as all ones and carries no valid code. When the parity bytes are all ones, the block first scans the 512 data bytes, two per cycle over both RAM ports. If every byte is 0xFF, it reports a clean result and changes nothing. Results are signalled by a one-cycle `done` pulse together with a fail flag and the number of corrections written.

Top module: `rs_sym_fixer`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low and `fixed_cnt` is 0.
- R2: A `start` seen while idle captures the status, error words and parity. `busy` is high from the next cycle until the cycle in which `done` pulses. A `start` given while busy has no effect on the operation in progress or its result.
- R3: Status bit 1 means the errors cannot be corrected. When it is set and the sector is not erased, `done` pulses with `fail`=1 and `fixed_cnt`=0, and no RAM write takes place. Without a scan, this happens one cycle after `start`.
- R4: Status bit 0 means errors were found, and status bits 31:29 hold the error count. If bit 0 is clear or the count is 0 (and bit 1 is clear), `done` pulses one cycle after `start` with `fail`=0, `fixed_cnt`=0 and no RAM writes. This holds when the parity is not all ones.
- R5: In an error word, bits 24:16 hold a 1-based symbol index and bits 8:0 hold the flip mask. A field value of 0 gives index -1 and is skipped, taking one cycle and no write.
- R6: For symbol index i, the low byte sits at address i + (i >> 3) and the high byte at the next address. Together they form a little-endian 16-bit word. The mask is XORed into the 9 bits that start at bit i & 7. Both bytes are written back, and the correction takes two cycles.
- R7: Error words are applied in order, word 0 first. The number processed is the status count, clamped to 4. Corrections that hit the same symbol accumulate.
- R8: If all 72 parity bits are ones and RAM bytes 0 to 511 all read 0xFF, `done` pulses 258 cycles after `start` with `fail`=0 and `fixed_cnt`=0, and nothing is written. This holds even if status bit 1 is set.
- R9: If the parity is all ones but some data byte differs from 0xFF, the 258-cycle scan is followed by the normal decision and corrections.
- R10: `done` is high for exactly one cycle. At that point `fixed_cnt` equals the number of corrections written, and `fail` and `fixed_cnt` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (used only when idle) |
| status_in | input | 32 | Decode status word |
| err_words_in | input | 128 | Four 32-bit error words, word 0 in bits 31:0 |
| parity_in | input | 72 | Parity bytes read with the sector |
| ram_addr_a | output | 10 | RAM port A byte address |
| ram_addr_b | output | 10 | RAM port B byte address |
| ram_we | output | 1 | Write both ports this cycle |
| ram_wdata_a | output | 8 | Write data, port A |
| ram_wdata_b | output | 8 | Write data, port B |
| ram_rdata_a | input | 8 | Read data, port A, one cycle after its address |
| ram_rdata_b | input | 8 | Read data, port B, one cycle after its address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sector could not be corrected |
| fixed_cnt | output | 3 | Number of corrections written |

## Verification
The assertions assume the RAM returns read data exactly one cycle after an address is presented. They also assume that nothing but this block writes the RAM while `busy` is high. The bench's RAM model meets the first assumption, and it fills the RAM only between operations, which meets the second. Captured inputs are assumed to change only on an accepted `start`. The bench tests this by pulsing `start` with conflicting values in the middle of an operation.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SCAN_LAST,
        ST_FIX_RD,
        ST_FIX_WR
    } fix_state_e;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 9;
endpackage

// File: rtl/rs_fix_locate.sv
module rs_fix_locate #(
    parameter int NUM_SYM = 512,
    parameter int ADDR_W  = 10
) (
    input  logic [31:0]       err_word,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        off,
    output logic [8:0]        mask
);
    logic [8:0] field;
    logic [8:0] idx;

    always_comb begin
        field = err_word[24:16];
        mask  = err_word[8:0];
        idx   = field - 9'd1;
        valid = (field != 9'd0) && (int'(idx) < NUM_SYM);
        off   = idx[2:0];
        addr  = ADDR_W'(idx) + ADDR_W'(idx >> 3);
    end
endmodule

// File: rtl/rs_fix_merge.sv
module rs_fix_merge (
    input  logic [7:0] lo_in,
    input  logic [7:0] hi_in,
    input  logic [8:0] mask,
    input  logic [2:0] off,
    output logic [7:0] lo_out,
    output logic [7:0] hi_out
);
    logic [15:0] pair;
    logic [15:0] flip;

    always_comb begin
        flip   = {7'd0, mask} << off;
        pair   = {hi_in, lo_in} ^ flip;
        lo_out = pair[7:0];
        hi_out = pair[15:8];
    end
endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer
    import rs_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int PAR_BYTES    = 9,
    parameter int MAX_ERR      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [31:0]                   status_in,
    input  logic [MAX_ERR*WORD_W-1:0]     err_words_in,
    input  logic [PAR_BYTES*8-1:0]        parity_in,
    output logic [$clog2(SECTOR_BYTES+SECTOR_BYTES/8)-1:0] ram_addr_a,
    output logic [$clog2(SECTOR_BYTES+SECTOR_BYTES/8)-1:0] ram_addr_b,
    output logic                          ram_we,
    output logic [7:0]                    ram_wdata_a,
    output logic [7:0]                    ram_wdata_b,
    input  logic [7:0]                    ram_rdata_a,
    input  logic [7:0]                    ram_rdata_b,
    output logic                          busy,
    output logic                          done,
    output logic                          fail,
    output logic [$clog2(MAX_ERR+1)-1:0]  fixed_cnt
);
    localparam int ADDR_W  = $clog2(SECTOR_BYTES + SECTOR_BYTES / 8);
    localparam int CNT_W   = $clog2(MAX_ERR + 1);
    localparam int K_W     = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
    localparam int SCAN_W  = $clog2(SECTOR_BYTES / 2);
    localparam int WORDS_W = MAX_ERR * WORD_W;
    localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SECTOR_BYTES / 2 - 1);

    typedef struct packed {
        fix_state_e         state;
        logic [SCAN_W-1:0]  scan;
        logic [K_W-1:0]     k;
        logic [CNT_W-1:0]   n;
        logic [CNT_W-1:0]   fixed;
        logic               ff_all;
        logic [31:0]        status;
        logic [WORDS_W-1:0] words;
        logic               done;
        logic               fail;
    } regs_t;

    regs_t r_q, r_d;

    // Current error word and its decoded location
    logic [31:0]       cur_word;
    logic              loc_valid;
    logic [ADDR_W-1:0] loc_addr;
    logic [2:0]        loc_off;
    logic [8:0]        loc_mask;
    logic [7:0]        new_lo, new_hi;

    assign cur_word = r_q.words[r_q.k*WORD_W +: WORD_W];

    rs_fix_locate #(.NUM_SYM(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_locate (
        .err_word (cur_word),
        .valid    (loc_valid),
        .addr     (loc_addr),
        .off      (loc_off),
        .mask     (loc_mask)
    );

    rs_fix_merge u_merge (
        .lo_in  (ram_rdata_a),
        .hi_in  (ram_rdata_b),
        .mask   (loc_mask),
        .off    (loc_off),
        .lo_out (new_lo),
        .hi_out (new_hi)
    );

    // Decision inputs: live status when idle, captured status otherwise
    logic [31:0]      dec_status;
    logic             dec_uncor, dec_trivial;
    logic [CNT_W-1:0] dec_n;
    logic             pair_ff, last_k, decide_now;

    always_comb begin
        dec_status  = (r_q.state == ST_IDLE) ? status_in : r_q.status;
        dec_uncor   = dec_status[1];
        dec_trivial = !dec_status[0] || (dec_status[31:29] == 3'd0);
        if (int'(dec_status[31:29]) > MAX_ERR) dec_n = CNT_W'(MAX_ERR);
        else                                    dec_n = CNT_W'(dec_status[31:29]);
        pair_ff = (&ram_rdata_a) && (&ram_rdata_b);
        last_k  = (CNT_W'(r_q.k) + CNT_W'(1)) == r_q.n;
    end

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        decide_now = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.status = status_in;
                    r_d.words  = err_words_in;
                    r_d.fixed  = '0;
                    r_d.fail   = 1'b0;
                    if (&parity_in) begin
                        r_d.state  = ST_SCAN;
                        r_d.scan   = '0;
                        r_d.ff_all = 1'b1;
                    end else begin
                        decide_now = 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (r_q.scan != '0) r_d.ff_all = r_q.ff_all & pair_ff;
                if (r_q.scan == SCAN_LAST) r_d.state = ST_SCAN_LAST;
                else                       r_d.scan  = r_q.scan + 1'b1;
            end
            ST_SCAN_LAST: begin
                if (r_q.ff_all && pair_ff) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    decide_now = 1'b1;
                end
            end
            ST_FIX_RD: begin
                if (loc_valid) begin
                    r_d.state = ST_FIX_WR;
                end else if (last_k) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.k = r_q.k + 1'b1;
                end
            end
            ST_FIX_WR: begin
                r_d.fixed = r_q.fixed + 1'b1;
                if (last_k) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.state = ST_FIX_RD;
                    r_d.k     = r_q.k + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (decide_now) begin
            if (dec_uncor) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.fail  = 1'b1;
            end else if (dec_trivial) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end else begin
                r_d.state = ST_FIX_RD;
                r_d.k     = '0;
                r_d.n     = dec_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.state == ST_SCAN) begin
            ram_addr_a = ADDR_W'({r_q.scan, 1'b0});
            ram_addr_b = ADDR_W'({r_q.scan, 1'b1});
        end else begin
            ram_addr_a = loc_addr;
            ram_addr_b = loc_addr + 1'b1;
        end
        ram_we      = (r_q.state == ST_FIX_WR);
        ram_wdata_a = new_lo;
        ram_wdata_b = new_hi;
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign fixed_cnt = r_q.fixed;

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: an uncorrectable capture never reaches the RAM write port
    assert_no_write_uncor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.status[1] && r_q.state != ST_SCAN && r_q.state != ST_SCAN_LAST) |-> !ram_we);

    // R3: a failure result requires the uncorrectable flag in the capture
    assert_fail_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> r_q.status[1]);

    // R2: captured inputs stay put while an operation runs
    assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.words) && $stable(r_q.status)));

    // R7: never more corrections than words processed
    assert_fixed_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fixed_cnt <= r_q.n || fixed_cnt == '0));

    // R6: a write always follows a read of the same pair
    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(r_q.state) == ST_FIX_RD && $stable(ram_addr_a)));
endmodule

// File: tb/rs_sym_fixer_bench.sv
module rs_sym_fixer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] status_in = '0;
    logic [127:0] err_words_in = '0;
    logic [71:0] parity_in = 72'h0123456789abcdef01;
    logic [9:0]  ram_addr_a, ram_addr_b;
    logic        ram_we;
    logic [7:0]  ram_wdata_a, ram_wdata_b;
    logic [7:0]  ram_rdata_a, ram_rdata_b;
    logic        busy, done, fail;
    logic [2:0]  fixed_cnt;

    logic [7:0] mem [0:1023];
    logic [7:0] img [0:1023];
    logic [7:0] exp_m [0:1023];
    logic       fill = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rs_sym_fixer u_rs_sym_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .status_in(status_in),
        .err_words_in(err_words_in), .parity_in(parity_in),
        .ram_addr_a(ram_addr_a), .ram_addr_b(ram_addr_b), .ram_we(ram_we),
        .ram_wdata_a(ram_wdata_a), .ram_wdata_b(ram_wdata_b),
        .ram_rdata_a(ram_rdata_a), .ram_rdata_b(ram_rdata_b),
        .busy(busy), .done(done), .fail(fail), .fixed_cnt(fixed_cnt)
    );

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 1024; i++) mem[i] <= img[i];
        end else begin
            ram_rdata_a <= mem[ram_addr_a];
            ram_rdata_b <= mem[ram_addr_b];
            if (ram_we) begin
                mem[ram_addr_a] <= ram_wdata_a;
                mem[ram_addr_b] <= ram_wdata_b;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ew(input int field, input int mask);
        return (32'(field) << 16) | 32'(mask);
    endfunction

    function automatic logic [31:0] st(input int cnt, input int unc, input int err);
        return (32'(cnt) << 29) | (32'(unc) << 1) | 32'(err);
    endfunction

    task automatic load_img();
        @(negedge clk); fill = 1'b1;
        @(negedge clk); fill = 1'b0;
    endtask

    // Behavioural reference: predicts memory, result and completion latency
    task automatic run_op(input string req, input logic [31:0] s, input logic [127:0] w,
                          input logic [71:0] p, input bit poke);
        int L, efix, cnt, n, sum;
        bit efail, scan, erased;
        for (int i = 0; i < 1024; i++) exp_m[i] = img[i];
        scan = (p == {72{1'b1}});
        erased = scan;
        for (int i = 0; i < 512; i++) if (img[i] != 8'hff) erased = 0;
        efix = 0; efail = 0; sum = 0;
        cnt = int'(s[31:29]);
        if (erased) begin
        end else if (s[1]) begin
            efail = 1;
        end else if (!s[0] || cnt == 0) begin
        end else begin
            n = (cnt > 4) ? 4 : cnt;
            for (int k = 0; k < n; k++) begin
                int f, ix, a, o, wd;
                f = int'(w[k*32+16 +: 9]);
                if (f == 0) begin
                    sum += 1;
                end else begin
                    ix = f - 1; a = ix + (ix >> 3); o = ix & 7;
                    wd = int'(exp_m[a]) | (int'(exp_m[a+1]) << 8);
                    wd = wd ^ (int'(w[k*32 +: 9]) << o);
                    exp_m[a] = 8'(wd); exp_m[a+1] = 8'(wd >> 8);
                    sum += 2; efix++;
                end
            end
        end
        L = (scan ? 258 : 1) + sum;

        load_img();
        @(negedge clk);
        status_in = s; err_words_in = w; parity_in = p; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 1; c <= L + 1; c++) begin
            if (c > 1) @(negedge clk);
            if (poke && c == 2 && L > 2) begin
                status_in = st(0, 1, 1); err_words_in = '0; start = 1'b1;
            end else if (poke && c == 3) begin
                start = 1'b0; status_in = s; err_words_in = w;
            end
            check(req, $sformatf("done at cycle %0d", c), int'(done), int'(c == L));
            check(req, $sformatf("busy at cycle %0d", c), int'(busy), int'(c < L));
            if (c == L) begin
                check(req, "fail", int'(fail), int'(efail));
                check(req, "fixed_cnt", int'(fixed_cnt), efix);
            end
            if (c == L + 1) begin
                check("R10", "fail held", int'(fail), int'(efail));
                check("R10", "fixed_cnt held", int'(fixed_cnt), efix);
            end
        end
        start = 1'b0;
        begin
            int bad;
            bad = -1;
            for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] != exp_m[i]) bad = i;
            n_checks++;
            if (bad >= 0) begin
                n_errors++;
                $display("FAIL %s ram[%0d]: actual=%0d expected=%0d", req, bad, mem[bad], exp_m[bad]);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) img[i] = 8'((i * 37 + 5) ^ (i >> 2));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "fail after reset", int'(fail), 0);
        check("R1", "fixed_cnt after reset", int'(fixed_cnt), 0);

        // R4: no-error flag, and zero count
        run_op("R4", st(2, 0, 0), {ew(30, 9'h1ff), ew(5, 9'h1ff), ew(2, 9'h1ff), ew(1, 9'h1ff)}, 72'h11, 0);
        run_op("R4", st(0, 0, 1), {4{ew(9, 9'h0ff)}}, 72'h22, 0);
        // R3: uncorrectable
        run_op("R3", st(3, 1, 1), {4{ew(12, 9'h1ff)}}, 72'h33, 0);
        // R5 R6: index 0, whole mask
        run_op("R6", st(1, 0, 1), {96'd0, ew(1, 9'h1ff)}, 72'h44, 0);
        // R6: index 7 straddles bytes 7 and 8 at bit offset 7
        run_op("R6", st(1, 0, 1), {96'd0, ew(8, 9'h155)}, 72'h55, 0);
        // R5 R7 R2: skipped field 0, highest index, busy start ignored
        run_op("R5", st(4, 0, 1), {ew(300, 9'h0a5), ew(100, 9'h13c), ew(511, 9'h1ff), ew(0, 9'h1ff)}, 72'h66, 1);
        // R7: count 7 clamps to 4, repeated symbol accumulates
        run_op("R7", st(7, 0, 1), {ew(51, 9'h100), ew(200, 9'h003), ew(50, 9'h00f), ew(50, 9'h0f0)}, 72'h77, 0);
        // R2: another poke during a single correction
        run_op("R2", st(2, 0, 1), {64'd0, ew(64, 9'h0c3), ew(65, 9'h111)}, 72'h88, 1);

        // R8: erased sector, even with the uncorrectable flag
        for (int i = 0; i < 512; i++) img[i] = 8'hff;
        run_op("R8", st(2, 1, 1), {4{ew(3, 9'h1ff)}}, {72{1'b1}}, 0);
        // R9: parity all ones but one data byte programmed
        img[200] = 8'hfe;
        run_op("R9", st(1, 0, 1), {96'd0, ew(3, 9'h001)}, {72{1'b1}}, 0);
        img[511] = 8'h7f; img[200] = 8'hff;
        run_op("R9", st(1, 1, 1), {96'd0, ew(3, 9'h001)}, {72{1'b1}}, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule